// File: doc/BRIEF.md
# Timekeeping Register Target on a Two-Wire Bus

This block lets a two-wire bus controller read and write a bank of eight byte-wide timekeeping registers. The two bus lines are sampled by the system clock through synchronizers. The block finds START and STOP conditions, decodes an address byte against its fixed 7-bit address, and answers by pulling SDA low through an open-drain enable. The register index follows a fixed order: 0 seconds, 1 minutes, 2 century and hours, 3 day, 4 date, 5 month, 6 year, 7 calibration.

A write transfer loads a register pointer from its first data byte. Every later byte lands in the pointed register, and the pointer then moves on. A read transfer returns bytes from the pointer onward, one per acknowledged byte. A power-fail input overrides everything else. While it is high, the transfer stops, the pointer returns to zero and the bus is ignored.

Top module: `rtc_i2c_target`

## Requirements
- R1: An address byte of 0xD0 (write) or 0xD1 (read), sent MSB first after a START, is acknowledged with SDA low during the ninth SCL pulse.
- R2: An address byte whose upper seven bits differ from 0x68 gets no acknowledge, and the data bytes that follow before the next START change no register.
- R3: In a write transfer, the first byte after the address sets the register pointer to that byte's low three bits.
- R4: Each further written byte is stored at the pointer, and the pointer then advances, going from index 7 back to 0.
- R5: In a read transfer, the register at the pointer is shifted out MSB first, valid while SCL is high, and the pointer advances after each byte. Advancement carries across transfers.
- R6: After the controller answers a read byte with NACK (SDA high on the ninth pulse), the target releases SDA and sends nothing more.
- R7: The target pulls SDA low during the ninth SCL pulse after each byte written to it in an accepted transfer.
- R8: A STOP (SDA rising while SCL is high) returns the target to idle and leaves the pointer unchanged.
- R9: While power-fail is high, SDA is released within one clock, the transfer in progress ends and the pointer becomes 0.
- R10: While power-fail is high, bus activity is neither acknowledged nor written. After it falls, the target responds only after a fresh START.
- R11: A repeated START in the middle of a transfer is recognized and begins a new address byte.
- R12: After reset, SDA is released, the pointer is 0 and all eight registers hold 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blocks bus access |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Two events can land in the same clock cycle: a power-fail abort and the commit of a finished write byte. Both fire on the falling SCL edge that ends the eighth data bit. The bench raises power-fail on the same clock edge as that SCL fall, so the abort is already active in the cycle where the commit would fire. Afterwards it reads the bank back over the bus. The targeted register must still hold its old value, and an unpointed read must start at index 0.

// File: rtl/rtc_tgt_pkg.sv
package rtc_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } xfer_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_ph_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic int ptr_next(input int p, input int n);
        return (p == n - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rtc_bus_sync.sv
module rtc_bus_sync
    import rtc_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.sda      = sda_s;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank #(
    parameter int NREG  = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] reg_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                reg_q[g] <= 8'h00;
            else if (we && (int'(widx) == g))
                reg_q[g] <= wdata;
        end

        // R4
        wr_take_chk: assert property (@(posedge clk) disable iff (rst)
            (we && (int'(widx) == g)) |=> (reg_q[g] == $past(wdata)));
    end

    assign rdata = reg_q[ridx];

endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
    import rtc_tgt_pkg::*;
#(
    parameter int         NREG        = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic pwr_fail,
    output logic sda_pull
);
    localparam int PTR_W = $clog2(NREG);

    bus_ev_t          ev;
    xfer_st_e         st;
    rx_ph_e           ph;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr, ptr_inc;
    logic             rd_mode;
    logic             pull_q;
    logic             reg_we;
    logic [7:0]       rdata;

    rtc_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    assign ptr_inc = PTR_W'(ptr_next(int'(ptr), NREG));

    assign reg_we = !pwr_fail && !ev.start && !ev.stop && (st == ST_RX)
                    && (ph == PH_DATA) && ev.scl_fall && (bitcnt == 4'd8);

    rtc_reg_bank #(.NREG(NREG), .PTR_W(PTR_W)) i_bank (
        .clk(clk), .rst(rst), .we(reg_we), .widx(ptr), .wdata(shreg),
        .ridx(ptr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ph      <= PH_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            pull_q  <= 1'b0;
        end else if (pwr_fail) begin
            st     <= ST_IDLE;
            ptr    <= '0;
            bitcnt <= '0;
            pull_q <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_RX;
            ph     <= PH_ADDR;
            bitcnt <= '0;
            pull_q <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            pull_q <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        unique case (ph)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rd_mode <= shreg[0];
                                    st      <= ST_RX_ACK;
                                    pull_q  <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            PH_PTR: begin
                                ptr    <= shreg[PTR_W-1:0];
                                st     <= ST_RX_ACK;
                                pull_q <= 1'b1;
                            end
                            default: begin
                                ptr    <= ptr_inc;
                                st     <= ST_RX_ACK;
                                pull_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (ph == PH_ADDR && rd_mode) begin
                            st     <= ST_TX;
                            shreg  <= rdata;
                            pull_q <= ~rdata[7];
                            ptr    <= ptr_inc;
                        end else begin
                            st     <= ST_RX;
                            ph     <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            st     <= ST_TX_ACK;
                            pull_q <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            pull_q <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise && ev.sda) begin
                        st <= ST_IDLE;
                    end else if (ev.scl_fall) begin
                        st     <= ST_TX;
                        shreg  <= rdata;
                        pull_q <= ~rdata[7];
                        ptr    <= ptr_inc;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull = pull_q;

    // R9
    pfail_release_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> !sda_pull);

    // R9
    pfail_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (ptr == '0));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !pwr_fail) |=> (st == ST_IDLE));

    // R8
    stop_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !pwr_fail) |=> (ptr == $past(ptr)));

    // R7
    ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX_ACK) |-> sda_pull);

endmodule

// File: tb/test_rtc_i2c_target.sv
module test_rtc_i2c_target;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic pwr_fail = 1'b0;
    logic sda_pull;
    logic sda_line;
    int   total = 0;
    int   bad = 0;
    logic [7:0] exp_reg [8];

    assign sda_line = ~(host_low | sda_pull);

    rtc_i2c_target i_rtc_i2c_target (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .pwr_fail(pwr_fail), .sda_pull(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        host_low = 1'b0; tick(Q);
        scl = 1'b1;      tick(2*Q);
        host_low = 1'b1; tick(2*Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; tick(Q);
        scl = 1'b1;      tick(2*Q);
        host_low = 1'b0; tick(2*Q);
    endtask

    task automatic send_bit(input bit b);
        host_low = ~b; tick(Q);
        scl = 1'b1;    tick(2*Q);
        scl = 1'b0;    tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        host_low = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            host_low = 1'b0; tick(Q);
            scl = 1'b1;      tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0;      tick(Q);
        end
        host_low = give_ack; tick(Q);
        scl = 1'b1;          tick(2*Q);
        scl = 1'b0;          tick(Q);
        host_low = 1'b0;
    endtask

    // reads n bytes starting at index first; optional pointer set with repeated START
    task automatic read_seq(input bit set_p, input int first, input int n, input string tag);
        bit a;
        logic [7:0] got;
        if (set_p) begin
            bus_start();
            send_byte(8'hD0, a);
            send_byte(8'(first), a);
        end
        bus_start();
        send_byte(8'hD1, a);
        check(a, "R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(got, (i != n - 1));
            check(got == exp_reg[(first + i) % 8], tag, got, exp_reg[(first + i) % 8]);
        end
        tick(4);
        check(sda_pull == 1'b0, "R6 release after NACK", sda_pull, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R12 SDA released after reset", sda_pull, 0);
        read_seq(1'b0, 0, 2, "R12 register zero after reset");
    endtask

    task automatic t_write_wrap();
        bit a;
        logic [7:0] d [4] = '{8'hA5, 8'hA6, 8'hA7, 8'h11};
        bus_start();
        send_byte(8'hD0, a);
        check(a, "R1 write address ack", a, 1);
        send_byte(8'h05, a);
        check(a, "R7 ack after pointer byte", a, 1);
        for (int i = 0; i < 4; i++) begin
            send_byte(d[i], a);
            check(a, "R7 ack after data byte", a, 1);
            exp_reg[(5 + i) % 8] = d[i];
        end
        bus_stop();
        // R11 repeated START between pointer set and read
        read_seq(1'b1, 5, 4, "R4 R5 R11 readback across wrap");
    endtask

    task automatic t_ptr_low();
        bit a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'hFB, a);
        send_byte(8'h3C, a);
        bus_stop();
        exp_reg[3] = 8'h3C;
        read_seq(1'b1, 3, 1, "R3 pointer from low three bits");
    endtask

    task automatic t_nomatch();
        bit a;
        bus_start();
        send_byte(8'hA0, a);
        check(!a, "R2 foreign address not acked", a, 0);
        send_byte(8'h02, a);
        check(!a, "R2 byte after foreign address not acked", a, 0);
        send_byte(8'h77, a);
        check(!a, "R2 data after foreign address not acked", a, 0);
        bus_stop();
        read_seq(1'b1, 2, 1, "R2 register unchanged");
    endtask

    task automatic t_stop_ptr();
        bit a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h06, a);
        bus_stop();
        read_seq(1'b0, 6, 1, "R8 pointer kept over STOP");
        read_seq(1'b0, 7, 1, "R5 pointer advance across transfers");
    endtask

    task automatic t_pfail_abort();
        bit a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h01, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        pwr_fail = 1'b1;
        tick(4);
        check(sda_pull == 1'b0, "R9 SDA released on power fail", sda_pull, 0);
        bus_start();
        send_byte(8'hD0, a);
        check(!a, "R10 no ack while power fail", a, 0);
        send_byte(8'h01, a);
        send_byte(8'h99, a);
        check(!a, "R10 no data ack while power fail", a, 0);
        bus_stop();
        pwr_fail = 1'b0;
        tick(4);
        send_byte(8'hD0, a);
        check(!a, "R10 no response without fresh START", a, 0);
        bus_stop();
        read_seq(1'b0, 0, 2, "R9 R10 pointer zero and no write");
    endtask

    task automatic t_coincide();
        bit a;
        logic [7:0] v = 8'h5A;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h04, a);
        for (int i = 7; i >= 1; i--) send_bit(v[i]);
        host_low = ~v[0]; tick(Q);
        scl = 1'b1;       tick(2*Q);
        pwr_fail = 1'b1;
        scl = 1'b0;       tick(8);
        check(sda_pull == 1'b0, "R9 no ack when abort meets commit", sda_pull, 0);
        pwr_fail = 1'b0;  tick(2);
        bus_stop();
        read_seq(1'b0, 0, 1, "R9 pointer zero after coincident abort");
        read_seq(1'b1, 4, 1, "R10 commit blocked by coincident abort");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_reg[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_wrap();
        t_ptr_low();
        t_nomatch();
        t_stop_ptr();
        t_pfail_abort();
        t_coincide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule